// File: doc/BRIEF.md
# Parallel Word Bit-Error-Rate Tester

This block measures the error behaviour of a link that carries parallel words. It sends one pseudorandom word per cycle and checks the words that come back. Each bit position of the word is its own serial lane. Every lane runs a maximal-length shift-register sequence of a different length, so the lanes produce independent sequences. On the receive side, each lane holds a reference register of the same length. The reference first trains on the incoming bits. After training it runs on its own prediction and is compared bit by bit with the received stream.

Lane 0 makes every control decision for the whole word. One state machine switches all lanes between training and measuring at the same moment. The same logic watches lane-0 mismatches to tell a slip of whole words apart from ordinary bit errors. Bit errors that fall inside a suspected slip are held back. If the slip is confirmed, those errors are discarded and the event is charged as one word slip. All lanes then retrain together.

The tester is wired in a loop with the device under test. Software or a test sequencer pulses `start`, waits for `measuring`, and reads the three counters.

Top module: `pword_bert`

## Requirements
- R1: After reset all three counters are zero, `measuring` is low and `tx_valid` stays low until `start` is pulsed. From then on `tx_valid` is high on every cycle and a new word appears on `tx_word` each cycle.
- R2: Bit i of `tx_word` is lane i and obeys b[n] = b[n-L] xor b[n-T]. The (L, T) pairs for lanes 0 to 7 are (7,6), (9,5), (10,7), (11,9), (15,14), (17,14), (20,17) and (23,18). The generator never stalls and never reseeds after the first `start`.
- R3: After `start`, and after every confirmed slip, the first 23 valid received words train the references and are not counted. Here 23 is the longest lane length. `measuring` rises after the 23rd word.
- R4: While measuring, each cycle with `rx_valid` high adds one to `word_count`. Cycles with `rx_valid` low have no effect, whatever `rx_word` holds.
- R5: For a measured word while no slip window is open, and whose lane-0 bit matches, the population count of (received xor expected) is added at once to `bit_err_count`.
- R6: A lane-0 mismatch opens a window of 8 measured words, counting the opening word. The bit errors of all lanes in that window are held back. When the window closes with fewer than 3 lane-0 mismatches, the held errors are added to `bit_err_count`.
- R7: When the window closes with 3 or more lane-0 mismatches, `slip_count` rises by one and the held errors are dropped. All lanes then return to training together (`measuring` low).
- R8: A `clear` pulse zeroes all three counters and leaves the tester state unchanged.
- R9: A `start` pulse while training or measuring closes any open window and restarts training. The transmit sequence continues without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: run the generator and (re)start training |
| clear | input | 1 | Pulse: zero the counters |
| tx_valid | output | 1 | Transmit word is valid |
| tx_word | output | LANES | Pseudorandom word to the device under test |
| rx_valid | input | 1 | Received word is valid |
| rx_word | input | LANES | Word returned by the device under test |
| measuring | output | 1 | High while received words are being compared |
| word_count | output | CNT_W | Measured words |
| bit_err_count | output | CNT_W | Accumulated bit errors |
| slip_count | output | CNT_W | Confirmed word slips |

## Verification
The bench loops recorded transmit words back into the receiver. It uses gaps, flipped bits, dropped words and repeated words. For each of these it predicts the counters from the recorded history.

- A lane-0 mismatch that opens a window, with exactly two lane-0 hits in it, must commit its errors late. A design that counts them at once, or drops them, gives the wrong error count.
- Three lane-0 hits in a row must give a slip. A design that keeps the window's bit errors, or fails to retrain, gives the wrong slip count, error count or `measuring` flag.
- A dropped or repeated word must end in a slip, not a flood of bit errors.
- The per-lane recurrence is checked over the whole run. A wrong tap, or a generator reseeded by a restart, breaks it.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_MEAS} chk_state_e;

  // Register length of lane i (maximal-length trinomials).
  function automatic int lane_len(input int i);
    case (i % 8)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 11;
      4: return 15;
      5: return 17;
      6: return 20;
      default: return 23;
    endcase
  endfunction

  // Second feedback position of lane i.
  function automatic int lane_tap(input int i);
    case (i % 8)
      0: return 6;
      1: return 5;
      2: return 7;
      3: return 9;
      4: return 14;
      5: return 14;
      6: return 17;
      default: return 18;
    endcase
  endfunction

  // Training length shared by all lanes: the longest register.
  function automatic int longest(input int k);
    int m;
    m = 0;
    for (int i = 0; i < k; i++)
      if (lane_len(i) > m) m = lane_len(i);
    return m;
  endfunction

endpackage

// File: rtl/pwb_prbs_gen.sv
module pwb_prbs_gen #(
  parameter int LEN  = 7,
  parameter int TAP  = 6,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bit_q
);
  logic [LEN-1:0] sr_q;
  logic           fb;

  assign fb = sr_q[LEN-1] ^ sr_q[TAP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= LEN'(SEED);
      bit_q <= 1'b0;
    end else if (run) begin
      sr_q  <= {sr_q[LEN-2:0], fb};
      bit_q <= fb;
    end
  end

  // R2: a running generator never locks up in the all-zero state
  p_gen_alive_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (sr_q != '0));

endmodule

// File: rtl/pwb_prbs_chk.sv
module pwb_prbs_chk #(
  parameter int LEN = 7,
  parameter int TAP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic meas_en,
  input  logic rx_bit,
  output logic miss
);
  logic [LEN-1:0] sr_q;
  logic           pred;

  assign pred = sr_q[LEN-1] ^ sr_q[TAP-1];
  assign miss = rx_bit ^ pred;

  always_ff @(posedge clk) begin
    if (rst)
      sr_q <= '0;
    else if (load_en)
      sr_q <= {sr_q[LEN-2:0], rx_bit};
    else if (meas_en)
      sr_q <= {sr_q[LEN-2:0], pred};
  end

endmodule

// File: rtl/pwb_lane0_ctrl.sv
module pwb_lane0_ctrl
  import pwb_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LOADW = 23,
  parameter int WIN   = 8,
  parameter int THR   = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clear,
  input  logic             rx_valid,
  input  logic [LANES-1:0] miss_vec,
  output logic             load_en,
  output logic             meas_en,
  output logic             gen_run,
  output logic             measuring,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] bit_err_cnt,
  output logic [CNT_W-1:0] slip_cnt
);
  localparam int LCW = $clog2(LOADW + 1);
  localparam int WCW = $clog2(WIN + 1);
  localparam int PW  = $clog2(WIN * LANES + 1);
  localparam int PCW = $clog2(LANES + 1);

  chk_state_e     st_q;
  logic [LCW-1:0] load_q;
  logic           win_q;
  logic [WCW-1:0] wcnt_q, wmiss_q, wcnt_nx, wmiss_nx;
  logic [PW-1:0]  pend_q, pend_nx;
  logic [PCW-1:0] pop;
  logic           in_win, closing, slip_hit;

  function automatic logic [PCW-1:0] popc(input logic [LANES-1:0] v);
    logic [PCW-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + PCW'(v[i]);
    return s;
  endfunction

  always_comb begin
    load_en  = rx_valid && !start && (st_q == ST_LOAD);
    meas_en  = rx_valid && !start && (st_q == ST_MEAS);
    pop      = popc(miss_vec);
    wcnt_nx  = win_q ? wcnt_q + 1'b1 : WCW'(1);
    wmiss_nx = (win_q ? wmiss_q : '0) + WCW'(miss_vec[0]);
    pend_nx  = (win_q ? pend_q : '0) + PW'(pop);
    in_win   = win_q || miss_vec[0];
    closing  = in_win && (wcnt_nx == WCW'(WIN));
    slip_hit = meas_en && closing && (wmiss_nx >= WCW'(THR));
  end

  assign measuring = (st_q == ST_MEAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      load_q      <= '0;
      win_q       <= 1'b0;
      wcnt_q      <= '0;
      wmiss_q     <= '0;
      pend_q      <= '0;
      gen_run     <= 1'b0;
      word_cnt    <= '0;
      bit_err_cnt <= '0;
      slip_cnt    <= '0;
    end else begin
      if (start) begin
        gen_run <= 1'b1;
        st_q    <= ST_LOAD;
        load_q  <= '0;
        win_q   <= 1'b0;
      end else if (load_en) begin
        load_q <= load_q + 1'b1;
        if (load_q == LCW'(LOADW - 1)) st_q <= ST_MEAS;
      end else if (meas_en) begin
        word_cnt <= word_cnt + 1'b1;
        if (!in_win) begin
          bit_err_cnt <= bit_err_cnt + CNT_W'(pop);
        end else if (!closing) begin
          win_q   <= 1'b1;
          wcnt_q  <= wcnt_nx;
          wmiss_q <= wmiss_nx;
          pend_q  <= pend_nx;
        end else begin
          win_q <= 1'b0;
          if (slip_hit) begin
            slip_cnt <= slip_cnt + 1'b1;
            st_q     <= ST_LOAD;
            load_q   <= '0;
          end else begin
            bit_err_cnt <= bit_err_cnt + CNT_W'(pend_nx);
          end
        end
      end
      if (clear) begin
        word_cnt    <= '0;
        bit_err_cnt <= '0;
        slip_cnt    <= '0;
      end
    end
  end

  // R4: idle receive cycles leave the counters alone
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !start && !clear) |=> ($stable(word_cnt) && $stable(bit_err_cnt)));

  // R7: a confirmed slip sends every lane back to training from word zero
  p_slip_reload_r7: assert property (@(posedge clk) disable iff (rst)
    slip_hit |=> (st_q == ST_LOAD && load_q == '0 && !win_q));

  // R6: an open window never runs past its length
  p_win_bound_r6: assert property (@(posedge clk) disable iff (rst)
    win_q |-> (wcnt_q < WCW'(WIN) && wmiss_q <= wcnt_q));

  // R3: no window survives outside measurement
  p_load_no_win_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_MEAS) |-> !win_q);

  // R5: the error count only grows unless cleared
  p_err_mono_r5: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (bit_err_cnt >= $past(bit_err_cnt)));

endmodule

// File: rtl/pword_bert.sv
module pword_bert
  import pwb_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIN   = 8,
  parameter int THR   = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clear,
  output logic             tx_valid,
  output logic [LANES-1:0] tx_word,
  input  logic             rx_valid,
  input  logic [LANES-1:0] rx_word,
  output logic             measuring,
  output logic [CNT_W-1:0] word_count,
  output logic [CNT_W-1:0] bit_err_count,
  output logic [CNT_W-1:0] slip_count
);
  localparam int LOADW = longest(LANES);

  logic             load_en, meas_en, gen_run;
  logic [LANES-1:0] miss_vec;

  pwb_lane0_ctrl #(
    .LANES(LANES), .LOADW(LOADW), .WIN(WIN), .THR(THR), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .clear      (clear),
    .rx_valid   (rx_valid),
    .miss_vec   (miss_vec),
    .load_en    (load_en),
    .meas_en    (meas_en),
    .gen_run    (gen_run),
    .measuring  (measuring),
    .word_cnt   (word_count),
    .bit_err_cnt(bit_err_count),
    .slip_cnt   (slip_count)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pwb_prbs_gen #(
      .LEN(lane_len(i)), .TAP(lane_tap(i)), .SEED(i + 1)
    ) u_gen (
      .clk  (clk),
      .rst  (rst),
      .run  (gen_run),
      .bit_q(tx_word[i])
    );
    pwb_prbs_chk #(
      .LEN(lane_len(i)), .TAP(lane_tap(i))
    ) u_chk (
      .clk    (clk),
      .rst    (rst),
      .load_en(load_en),
      .meas_en(meas_en),
      .rx_bit (rx_word[i]),
      .miss   (miss_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tx_valid <= 1'b0;
    else     tx_valid <= gen_run;
  end

endmodule

// File: tb/pword_bert_test.sv
`timescale 1ns/1ps
module pword_bert_test;
  localparam int K     = 8;
  localparam int LOADW = 23;
  localparam int WIN   = 8;
  localparam int THR   = 3;
  localparam int HMAX  = 16384;
  localparam int LL [8] = '{7, 9, 10, 11, 15, 17, 20, 23};
  localparam int TT [8] = '{6, 5, 7, 9, 14, 14, 17, 18};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         clear = 1'b0;
  logic         tx_valid;
  logic [K-1:0] tx_word;
  logic         rx_valid = 1'b0;
  logic [K-1:0] rx_word = '0;
  logic         measuring;
  logic [31:0]  word_count, bit_err_count, slip_count;

  pword_bert uut (
    .clk(clk), .rst(rst), .start(start), .clear(clear),
    .tx_valid(tx_valid), .tx_word(tx_word),
    .rx_valid(rx_valid), .rx_word(rx_word),
    .measuring(measuring), .word_count(word_count),
    .bit_err_count(bit_err_count), .slip_count(slip_count)
  );

  always #5 clk = ~clk;

  logic [K-1:0] hist [0:HMAX-1];
  int wr = 0;
  int rd = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 training, 2 measuring
  int     mst = 0, mload = 0, mexp = 0, mwc = 0, mwm = 0, mpend = 0;
  bit     mwin = 1'b0;
  longint mwords = 0, merrs = 0, mslips = 0;

  always @(negedge clk)
    if (tx_valid && wr < HMAX) begin
      hist[wr] = tx_word;
      wr++;
    end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [K-1:0] v);
    logic [K-1:0] e;
    int p, wc, wm, pd;
    if (mst == 1) begin
      mload++;
      if (mload == LOADW) begin
        mst = 2;
        mexp = rd;
      end
    end else if (mst == 2) begin
      e = v ^ hist[mexp];
      mexp++;
      mwords++;
      p = $countones(e);
      if (!mwin && !e[0]) merrs += p;
      else begin
        wc = mwin ? mwc + 1 : 1;
        wm = (mwin ? mwm : 0) + int'(e[0]);
        pd = (mwin ? mpend : 0) + p;
        if (wc == WIN) begin
          mwin = 1'b0;
          if (wm >= THR) begin
            mslips++;
            mst = 1;
            mload = 0;
          end else merrs += pd;
        end else begin
          mwin = 1'b1; mwc = wc; mwm = wm; mpend = pd;
        end
      end
    end
  endtask

  // skip: 1 drops one word, -1 repeats the previous word
  task automatic push(input logic [K-1:0] flip, input int skip);
    logic [K-1:0] v;
    repeat ($urandom_range(0, 1)) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_word  = K'($urandom);
    end
    while (rd + 2 >= wr) @(negedge clk);
    if (skip == 1) rd++;
    if (skip == -1) rd--;
    v = hist[rd] ^ flip;
    rd++;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_word  = v;
    model_step(v);
  endtask

  task automatic push_clean(input int n);
    for (int i = 0; i < n; i++) push('0, 0);
  endtask

  task automatic settle();
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    settle();
    chk({tag, " R4 word_count"}, word_count, mwords);
    chk({tag, " R5 bit_err_count"}, bit_err_count, merrs);
    chk({tag, " R7 slip_count"}, slip_count, mslips);
    chk({tag, " R3 measuring"}, measuring, (mst == 2));
  endtask

  task automatic pulse_start();
    @(negedge clk);
    rx_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mst = 1; mload = 0; mwin = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    longint e0, s0;
    int bad;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state and idle generator
    chk("R1 reset word_count", word_count, 0);
    chk("R1 reset bit_err_count", bit_err_count, 0);
    chk("R1 reset slip_count", slip_count, 0);
    chk("R1 reset measuring", measuring, 0);
    repeat (3) @(negedge clk);
    chk("R1 tx_valid before start", tx_valid, 0);

    pulse_start();
    repeat (30) @(negedge clk);
    chk("R1 tx_valid after start", tx_valid, 1);

    // R3 training length
    push_clean(LOADW - 1);
    settle();
    chk("R3 not measuring after 22 words", measuring, 0);
    chk("R3 no words counted in training", word_count, 0);
    push_clean(1);
    settle();
    chk("R3 measuring after 23 words", measuring, 1);

    push_clean(60);
    check_all("clean");

    // R4 idle cycles with garbage data are ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_word  = K'($urandom);
    end
    check_all("R4 idle garbage");

    // R5 errors on lanes 1..7 only
    for (int i = 0; i < 40; i++)
      push(($urandom_range(0, 1) == 1) ? (K'($urandom) & ~K'(1)) : '0, 0);
    check_all("R5 lanes1-7");

    // R6 single lane-0 hits commit late
    for (int j = 0; j < 3; j++) begin
      push(K'(1) | K'($urandom), 0);
      push_clean(10);
    end
    // R6 exactly THR-1 lane-0 hits in one window
    e0 = merrs;
    push(K'(8'h03), 0);
    push_clean(2);
    push(K'(8'h81), 0);
    settle();
    chk("R6 held errors not yet counted", bit_err_count, e0);
    push_clean(6);
    check_all("R6 two hits");
    chk("R6 no slip on two hits", slip_count, 0);

    // R7 three lane-0 hits in a row
    e0 = merrs;
    push(K'(8'h0F), 0);
    push(K'(8'h11), 0);
    push(K'(8'h41), 0);
    push_clean(5);
    check_all("R7 burst");
    chk("R7 burst slip counted", slip_count, 1);
    chk("R7 burst errors discarded", bit_err_count, e0);
    chk("R7 back to training", measuring, 0);
    push_clean(LOADW);
    check_all("R7 retrained");

    // R8 clear
    push_clean(10);
    settle();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    mwords = 0; merrs = 0; mslips = 0;
    check_all("R8 clear");
    chk("R8 clear keeps measuring", measuring, 1);

    // R7 dropped word
    s0 = mslips;
    push('0, 1);
    for (int i = 0; i < 300 && mslips == s0; i++) push('0, 0);
    push_clean(LOADW + 5);
    check_all("R7 drop");
    chk("R7 drop gives one slip", mslips - s0, 1);

    // R7 repeated word
    s0 = mslips;
    push('0, -1);
    for (int i = 0; i < 300 && mslips == s0; i++) push('0, 0);
    push_clean(LOADW + 5);
    check_all("R7 repeat");
    chk("R7 repeat gives one slip", mslips - s0, 1);

    // R9 restart while measuring
    pulse_start();
    settle();
    chk("R9 restart drops measuring", measuring, 0);
    push_clean(LOADW);
    check_all("R9 restart");

    // mixed random phase
    for (int i = 0; i < 400; i++) begin
      int sk;
      logic [K-1:0] f;
      sk = (mst == 2 && !mwin && $urandom_range(0, 99) == 0) ? 1 : 0;
      f  = (mst == 2 && sk == 0 && $urandom_range(0, 9) == 0) ? K'($urandom) : '0;
      push(f, sk);
    end
    push_clean(LOADW + WIN);
    check_all("random");

    // R2 per-lane recurrence over the recorded stream
    for (int ln = 0; ln < K; ln++) begin
      bad = 0;
      for (int n = LL[ln]; n < wr; n++)
        if (hist[n][ln] !== (hist[n - LL[ln]][ln] ^ hist[n - TT[ln]][ln])) bad++;
      chk($sformatf("R2 lane %0d recurrence", ln), bad, 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule